// File: doc/BRIEF.md
# Signature-Addressed Load/Store Buffer

This block is a small, fully associative data buffer that is looked up with a memory signature rather than a computed address. A signature joins two things: the color of the base register and the displacement of the memory instruction. A color table gives every architectural register a color tag. Whenever a register is written, it gets a new color that no other register holds at that moment. Two operations with the same signature therefore name the same memory word, and a match counts as a real hit, not a guess.

Loads and stores present a base register index and a displacement straight after decode. The block never needs the register's value or an address adder. A store writes its data under its signature, which gives store-to-load forwarding. A load reports hit or miss and its data in the same cycle. When a load misses, its signature is reported to the caller. The caller later returns the cache data with that signature as a fill, so the next load with the same signature hits.

Top module: `sigbuf_top`

## Requirements
- R1: After reset, register i holds color i and every buffer entry is invalid, so every load misses.
- R2: The signature is the base register's current color followed by the 16-bit displacement. `ld_color` always shows the color that register `ld_reg` holds in the current cycle.
- R3: On a register write event (`rw_valid`), the register is given the first color, counting upward modulo 64 from an allocation pointer, that no register holds. The pointer starts at the register count and moves to one past the chosen color. A load or store in the same cycle still uses the old color; the new color applies from the next cycle.
- R4: On a register write event, every entry tagged with the newly chosen color is invalidated. A fill in the same cycle that carries that color is discarded. The register's next load therefore misses.
- R5: A store writes its data under its signature, and a later load with that signature hits with that data. A store whose signature is already present overwrites that entry in place.
- R6: A load reports hit and data combinationally in its own request cycle. With `ld_valid` low, `ld_hit` is 0.
- R7: A fill writes its data under its signature, so a later load with that signature hits. A fill whose signature is already present is discarded, and the existing data is kept.
- R8: When a store and a load with the same signature arrive in the same cycle, the load hits and returns the store's data.
- R9: When a store and a fill arrive in the same cycle, the fill is discarded.
- R10: A new entry goes into the lowest-index invalid entry if one exists; otherwise it replaces the least recently used entry. Stores, accepted fills and load hits mark an entry as most recent. When a write and a load hit fall in the same cycle, only the write marks recency. No entry is lost except by replacement or by R4.
- R11: At most one valid entry matches any signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rw_valid | input | 1 | Register write event: give `rw_reg` a new color |
| rw_reg | input | 5 | Register being written |
| ld_valid | input | 1 | Load request |
| ld_reg | input | 5 | Load base register index |
| ld_disp | input | 16 | Load displacement |
| ld_hit | output | 1 | Load hit, same cycle |
| ld_data | output | 64 | Load data when hit |
| ld_color | output | 6 | Current color of `ld_reg`, kept for a later fill |
| st_valid | input | 1 | Store request |
| st_reg | input | 5 | Store base register index |
| st_disp | input | 16 | Store displacement |
| st_data | input | 64 | Store data |
| fill_valid | input | 1 | Fill after a load miss |
| fill_color | input | 6 | Color reported by the missing load |
| fill_disp | input | 16 | Displacement of the missing load |
| fill_data | input | 64 | Data returned by the cache |

## Verification
The assertions assume three things about the inputs. A fill carries a color that a recent miss reported. That fill returns before the allocator could hand the same color out again. Register indices stay below the register count. Under these assumptions, a stale fill can never land under a color that a register has just taken over. The directed tests issue every fill within a few cycles of its miss. They drive the allocator through its modulo-64 wrap only with register writes, so the only way an old color comes back is the reissue that R4 covers.

// File: rtl/sigbuf_pkg.sv
// Shared widths and the signature type for the signature-addressed buffer.
package sigbuf_pkg;
    localparam int SB_COLOR_W = 6;
    localparam int SB_DISP_W  = 16;
    localparam int SB_DATA_W  = 64;

    typedef logic [SB_COLOR_W-1:0] color_t;
    typedef logic [SB_DISP_W-1:0]  disp_t;
    typedef logic [SB_DATA_W-1:0]  data_t;

    typedef struct packed {
        color_t color;
        disp_t  disp;
    } sig_t;
endpackage

// File: rtl/sigbuf_color_table.sv
// Register color table: holds one color per architectural register and hands
// out a color no register holds when a register is written.
// Assumes NUM_REGS is smaller than the number of colors, so a free color exists.
module sigbuf_color_table
    import sigbuf_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int RIDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rw_valid,
    input  logic [RIDX_W-1:0] rw_reg,
    input  logic [RIDX_W-1:0] ld_reg,
    input  logic [RIDX_W-1:0] st_reg,
    output color_t            ld_color,
    output color_t            st_color,
    output color_t            new_color
);
    localparam int NCOLORS = 1 << SB_COLOR_W;

    color_t             color_q [NUM_REGS];
    color_t             ptr_q;
    logic [NCOLORS-1:0] live;
    color_t             cand;
    logic               found;

    assign ld_color = color_q[ld_reg];
    assign st_color = color_q[st_reg];

    // Mark every color currently held by some register.
    always_comb begin
        live = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            live[color_q[r]] = 1'b1;
        end
    end

    // Pick the first color at or after the pointer that is not live.
    always_comb begin
        new_color = ptr_q;
        found     = 1'b0;
        cand      = '0;
        for (int i = 0; i < NCOLORS; i++) begin
            cand = ptr_q + color_t'(i);
            if (!found && !live[cand]) begin
                new_color = cand;
                found     = 1'b1;
            end
        end
    end

    // Load identity colors at reset; recolor the written register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                color_q[r] <= color_t'(r);
            end
            ptr_q <= color_t'(NUM_REGS);
        end else if (rw_valid) begin
            color_q[rw_reg] <= new_color;
            ptr_q           <= new_color + color_t'(1);
        end
    end
endmodule

// File: rtl/sigbuf_entry_store.sv
// Entry storage: valid bit, signature and data per entry, one write port and
// a color-wide invalidate. Assumes the writer never writes the color being
// invalidated in the same cycle.
module sigbuf_entry_store
    import sigbuf_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  sig_t               wsig,
    input  data_t              wdata,
    input  logic               inv_en,
    input  color_t             inv_color,
    output logic [ENTRIES-1:0] ent_valid,
    output sig_t               ent_sig  [ENTRIES],
    output data_t              ent_data [ENTRIES]
);
    // Clear on reset; apply color invalidation, then the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_en && ent_sig[i].color == inv_color) begin
                    ent_valid[i] <= 1'b0;
                end
                if (we && widx == IDX_W'(i)) begin
                    ent_valid[i] <= 1'b1;
                end
            end
        end
    end

    // Signature and data need no reset; the valid bit guards them.
    always_ff @(posedge clk) begin
        if (we) begin
            ent_sig[widx]  <= wsig;
            ent_data[widx] <= wdata;
        end
    end
endmodule

// File: rtl/sigbuf_match.sv
// Fully associative compare of one key against all entries.
// Assumes at most one entry matches (kept true by the writer).
module sigbuf_match
    import sigbuf_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  sig_t               ent_sig  [ENTRIES],
    input  data_t              ent_data [ENTRIES],
    input  sig_t               key,
    output logic [ENTRIES-1:0] hit_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output data_t              hit_data
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_sig[i] == key);
    end

    assign hit = |hit_vec;

    // Encode the matching entry's index and select its data.
    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx  = IDX_W'(i);
                hit_data = ent_data[i];
            end
        end
    end
endmodule

// File: rtl/sigbuf_lru.sv
// Exact LRU order kept as a per-entry age rank (0 = most recent) and the
// allocation choice: lowest invalid entry first, else the oldest entry.
// Assumes ENTRIES >= 2.
module sigbuf_lru #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] oldest_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Find the oldest entry and the lowest-index invalid entry.
    always_comb begin
        oldest_idx = '0;
        free_idx   = '0;
        any_free   = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (age_q[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        victim_idx = any_free ? free_idx : oldest_idx;
    end

    // Move the touched entry to rank 0 and age those that were younger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (touch_idx == IDX_W'(i)) age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sigbuf_top.sv
// Signature-addressed load/store buffer. Loads and stores are looked up by
// {base register color, displacement} straight after decode. Stores write
// through, load misses are filled later by the caller with the color from
// ld_color. Assumes a fill returns before its color can be reissued.
module sigbuf_top
    import sigbuf_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int ENTRIES  = 8,
    localparam int RIDX_W   = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rw_valid,
    input  logic [RIDX_W-1:0]     rw_reg,
    input  logic                  ld_valid,
    input  logic [RIDX_W-1:0]     ld_reg,
    input  logic [SB_DISP_W-1:0]  ld_disp,
    output logic                  ld_hit,
    output logic [SB_DATA_W-1:0]  ld_data,
    output logic [SB_COLOR_W-1:0] ld_color,
    input  logic                  st_valid,
    input  logic [RIDX_W-1:0]     st_reg,
    input  logic [SB_DISP_W-1:0]  st_disp,
    input  logic [SB_DATA_W-1:0]  st_data,
    input  logic                  fill_valid,
    input  logic [SB_COLOR_W-1:0] fill_color,
    input  logic [SB_DISP_W-1:0]  fill_disp,
    input  logic [SB_DATA_W-1:0]  fill_data
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int K_LD  = 0;
    localparam int K_ST  = 1;
    localparam int K_FL  = 2;
    localparam int NKEYS = 3;

    color_t             st_color;
    color_t             new_color;
    logic [ENTRIES-1:0] ent_valid;
    sig_t               ent_sig  [ENTRIES];
    data_t              ent_data [ENTRIES];
    sig_t               keys     [NKEYS];
    logic [ENTRIES-1:0] m_vec    [NKEYS];
    logic [NKEYS-1:0]   m_hit;
    logic [IDX_W-1:0]   m_idx    [NKEYS];
    data_t              m_data   [NKEYS];
    logic [ENTRIES-1:0] ld_hit_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               fwd, fill_ok, we, touch_en;
    logic [IDX_W-1:0]   widx, touch_idx;
    sig_t               wsig;
    data_t              wdata;

    sigbuf_color_table #(.NUM_REGS(NUM_REGS)) u_colors (
        .clk(clk), .rst_n(rst_n), .rw_valid(rw_valid), .rw_reg(rw_reg),
        .ld_reg(ld_reg), .st_reg(st_reg), .ld_color(ld_color),
        .st_color(st_color), .new_color(new_color)
    );

    assign keys[K_LD] = '{color: ld_color,   disp: ld_disp};
    assign keys[K_ST] = '{color: st_color,   disp: st_disp};
    assign keys[K_FL] = '{color: fill_color, disp: fill_disp};

    for (genvar k = 0; k < NKEYS; k++) begin : g_match
        sigbuf_match #(.ENTRIES(ENTRIES)) u_match (
            .ent_valid(ent_valid), .ent_sig(ent_sig), .ent_data(ent_data),
            .key(keys[k]), .hit_vec(m_vec[k]), .hit(m_hit[k]),
            .hit_idx(m_idx[k]), .hit_data(m_data[k])
        );
    end

    assign ld_hit_vec = m_vec[K_LD];

    // Load result: same-cycle store forwarding wins over the stored entry.
    always_comb begin
        fwd     = st_valid && ld_valid && (keys[K_ST] == keys[K_LD]);
        ld_hit  = ld_valid && (fwd || m_hit[K_LD]);
        ld_data = '0;
        if (ld_valid && fwd)              ld_data = st_data;
        else if (ld_valid && m_hit[K_LD]) ld_data = m_data[K_LD];
    end

    // Single write port: store first, else a fill that is new and not stale.
    always_comb begin
        fill_ok = fill_valid && !st_valid && !m_hit[K_FL]
                  && !(rw_valid && fill_color == new_color);
        we      = st_valid || fill_ok;
        if (st_valid) begin
            widx  = m_hit[K_ST] ? m_idx[K_ST] : victim_idx;
            wsig  = keys[K_ST];
            wdata = st_data;
        end else begin
            widx  = victim_idx;
            wsig  = keys[K_FL];
            wdata = fill_data;
        end
        touch_en  = we || (ld_valid && m_hit[K_LD]);
        touch_idx = we ? widx : m_idx[K_LD];
    end

    sigbuf_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wsig(wsig),
        .wdata(wdata), .inv_en(rw_valid), .inv_color(new_color),
        .ent_valid(ent_valid), .ent_sig(ent_sig), .ent_data(ent_data)
    );

    sigbuf_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
        .ent_valid(ent_valid), .victim_idx(victim_idx)
    );
endmodule

// File: rtl/sigbuf_checker.sv
// Property checker for sigbuf_top, attached by bind.
module sigbuf_checker
    import sigbuf_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int ENTRIES  = 8,
    localparam int RIDX_W   = $clog2(NUM_REGS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rw_valid,
    input logic [RIDX_W-1:0]  rw_reg,
    input logic               ld_valid,
    input logic [RIDX_W-1:0]  ld_reg,
    input disp_t              ld_disp,
    input logic               ld_hit,
    input data_t              ld_data,
    input color_t             ld_color,
    input logic               st_valid,
    input color_t             st_color,
    input disp_t              st_disp,
    input data_t              st_data,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] ld_hit_vec
);
    // A stored signature is readable by a load in the next cycle.
    assert_store_then_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> ((ld_valid && !st_valid && ld_color == $past(st_color)
                       && ld_disp == $past(st_disp)) |-> (ld_hit && ld_data == $past(st_data))));

    // Same-cycle store and load with one signature forward the store data.
    assert_same_cycle_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ld_valid && st_color == ld_color && st_disp == ld_disp)
        |-> (ld_hit && ld_data == st_data));

    // No two entries share a signature.
    assert_unique_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_hit_vec));

    // A freshly recolored register cannot hit on stale entries.
    assert_recolor_misses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rw_valid |=> ((ld_valid && !st_valid && ld_reg == $past(rw_reg)) |-> !ld_hit));

    // Without a recolor, the count of valid entries never drops.
    assert_valid_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_valid |=> ($countones(ent_valid) >= $past($countones(ent_valid))));

    // An idle load port reports no hit.
    assert_idle_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_hit);
endmodule

bind sigbuf_top sigbuf_checker #(.NUM_REGS(NUM_REGS), .ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rw_valid(rw_valid), .rw_reg(rw_reg),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_disp(ld_disp), .ld_hit(ld_hit),
    .ld_data(ld_data), .ld_color(ld_color), .st_valid(st_valid),
    .st_color(st_color), .st_disp(st_disp), .st_data(st_data),
    .ent_valid(ent_valid), .ld_hit_vec(ld_hit_vec)
);

// File: tb/sim_sigbuf_top.sv
// Directed bench for sigbuf_top: one task per scenario, each checking itself.
module sim_sigbuf_top;
    import sigbuf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rw_valid = 1'b0;
    logic [4:0]  rw_reg = '0;
    logic        ld_valid = 1'b0;
    logic [4:0]  ld_reg = '0;
    logic [15:0] ld_disp = '0;
    logic        ld_hit;
    logic [63:0] ld_data;
    logic [5:0]  ld_color;
    logic        st_valid = 1'b0;
    logic [4:0]  st_reg = '0;
    logic [15:0] st_disp = '0;
    logic [63:0] st_data = '0;
    logic        fill_valid = 1'b0;
    logic [5:0]  fill_color = '0;
    logic [15:0] fill_disp = '0;
    logic [63:0] fill_data = '0;

    int checks = 0;
    int fails  = 0;

    logic [5:0] mcol [32];
    logic [5:0] mptr;

    always #10 clk = ~clk;

    sigbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .rw_valid(rw_valid), .rw_reg(rw_reg),
        .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_disp(ld_disp),
        .ld_hit(ld_hit), .ld_data(ld_data), .ld_color(ld_color),
        .st_valid(st_valid), .st_reg(st_reg), .st_disp(st_disp),
        .st_data(st_data), .fill_valid(fill_valid), .fill_color(fill_color),
        .fill_disp(fill_disp), .fill_data(fill_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Model of the allocator: first color from the pointer held by no register.
    function automatic logic [5:0] model_next();
        for (int i = 0; i < 64; i++) begin
            logic [5:0] c;
            bit held;
            c = mptr + 6'(i);
            held = 1'b0;
            for (int r = 0; r < 32; r++) if (mcol[r] == c) held = 1'b1;
            if (!held) return c;
        end
        return mptr;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rw_valid = 0; ld_valid = 0; st_valid = 0; fill_valid = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) mcol[r] = 6'(r);
        mptr = 6'd32;
    endtask

    task automatic do_store(input logic [4:0] r, input logic [15:0] d, input logic [63:0] v);
        st_valid = 1; st_reg = r; st_disp = d; st_data = v;
        tick();
        st_valid = 0;
    endtask

    task automatic do_fill(input logic [5:0] c, input logic [15:0] d, input logic [63:0] v);
        fill_valid = 1; fill_color = c; fill_disp = d; fill_data = v;
        tick();
        fill_valid = 0;
    endtask

    task automatic do_recolor(input logic [4:0] r);
        logic [5:0] c;
        c = model_next();
        rw_valid = 1; rw_reg = r;
        tick();
        rw_valid = 0;
        mcol[r] = c;
        mptr = c + 6'd1;
    endtask

    task automatic check_load(input logic [4:0] r, input logic [15:0] d, input bit exp_hit,
                              input logic [63:0] exp_data, input string req);
        ld_valid = 1; ld_reg = r; ld_disp = d;
        #1;
        chk(ld_hit === exp_hit, req, 64'(ld_hit), 64'(exp_hit));
        if (exp_hit) chk(ld_data === exp_data, req, ld_data, exp_data);
        chk(ld_color === mcol[r], "R2 color", 64'(ld_color), 64'(mcol[r]));
        tick();
        ld_valid = 0;
    endtask

    // R1: identity colors and empty buffer after reset.
    task automatic t_reset();
        do_reset();
        check_load(5'd5, 16'd0, 0, 0, "R1 empty after reset");
        check_load(5'd31, 16'hffff, 0, 0, "R1 empty after reset");
        #1;
        chk(ld_hit === 1'b0, "R6 idle load no hit", 64'(ld_hit), 0);
    endtask

    // R5, R11: store/load, signature separation, in-place update.
    task automatic t_store_load();
        do_reset();
        do_store(5'd4, 16'd16, 64'h1111_2222_3333_4444);
        check_load(5'd4, 16'd16, 1, 64'h1111_2222_3333_4444, "R5 store then load");
        check_load(5'd4, 16'd17, 0, 0, "R2 other displacement misses");
        check_load(5'd5, 16'd16, 0, 0, "R2 other color misses");
        do_store(5'd4, 16'd16, 64'hdead_beef);
        check_load(5'd4, 16'd16, 1, 64'hdead_beef, "R5 R11 in-place update");
    endtask

    // R8: same-cycle store and load share one signature.
    task automatic t_same_cycle();
        do_reset();
        st_valid = 1; st_reg = 5'd7; st_disp = 16'd40; st_data = 64'habcd;
        ld_valid = 1; ld_reg = 5'd7; ld_disp = 16'd40;
        #1;
        chk(ld_hit === 1'b1, "R8 forward hit", 64'(ld_hit), 1);
        chk(ld_data === 64'habcd, "R8 forward data", ld_data, 64'habcd);
        tick();
        st_valid = 0; ld_valid = 0;
        check_load(5'd7, 16'd40, 1, 64'habcd, "R8 stored after forward");
    endtask

    // R7: miss then fill, duplicate fill ignored; R9: store beats fill.
    task automatic t_fill();
        do_reset();
        check_load(5'd6, 16'd0, 0, 0, "R7 miss before fill");
        do_fill(mcol[6], 16'd0, 64'h5a5a);
        check_load(5'd6, 16'd0, 1, 64'h5a5a, "R7 fill then load");
        do_fill(mcol[6], 16'd0, 64'h7777);
        check_load(5'd6, 16'd0, 1, 64'h5a5a, "R7 duplicate fill ignored");
        st_valid = 1; st_reg = 5'd8; st_disp = 16'd2; st_data = 64'hA;
        fill_valid = 1; fill_color = mcol[8]; fill_disp = 16'd3; fill_data = 64'hB;
        tick();
        st_valid = 0; fill_valid = 0;
        check_load(5'd8, 16'd3, 0, 0, "R9 fill dropped");
        check_load(5'd8, 16'd2, 1, 64'hA, "R9 store kept");
    endtask

    // R3, R4: recolor, stale entries unreachable, same-cycle fill dropped.
    task automatic t_recolor();
        logic [5:0] c;
        do_reset();
        do_store(5'd4, 16'd16, 64'h42);
        do_recolor(5'd4);
        chk(mcol[4] == 6'd32, "R3 model sanity", 64'(mcol[4]), 32);
        check_load(5'd4, 16'd16, 0, 0, "R3 R4 recolored register misses");
        c = model_next();
        rw_valid = 1; rw_reg = 5'd9;
        fill_valid = 1; fill_color = c; fill_disp = 16'd0; fill_data = 64'h99;
        tick();
        rw_valid = 0; fill_valid = 0;
        mcol[9] = c; mptr = c + 6'd1;
        check_load(5'd9, 16'd0, 0, 0, "R4 fill with new color dropped");
    endtask

    // R3, R4, R10: color wrap reissues a stale color; hole reused before LRU.
    task automatic t_wrap();
        do_reset();
        do_store(5'd1, 16'd4, 64'hF00D);
        for (int k = 0; k < 7; k++) do_store(5'd2, 16'(k), 64'(100 + k));
        do_recolor(5'd1);
        for (int n = 0; n < 100 && mcol[0] != 6'd1; n++) do_recolor(5'd0);
        chk(mcol[0] == 6'd1, "R3 wrap reaches color 1", 64'(mcol[0]), 1);
        check_load(5'd0, 16'd4, 0, 0, "R4 reissued color invalidated");
        do_store(5'd3, 16'd0, 64'hCAFE);
        for (int k = 0; k < 7; k++)
            check_load(5'd2, 16'(k), 1, 64'(100 + k), "R10 invalid entry used first");
        check_load(5'd3, 16'd0, 1, 64'hCAFE, "R10 new entry present");
    endtask

    // R10: least recently used entry is replaced; load hit refreshes.
    task automatic t_lru();
        do_reset();
        for (int k = 0; k < 8; k++) do_store(5'd2, 16'(8 * k), 64'(200 + k));
        check_load(5'd2, 16'd0, 1, 64'd200, "R10 touch oldest");
        do_store(5'd2, 16'd64, 64'd208);
        check_load(5'd2, 16'd8, 0, 0, "R10 lru evicted");
        check_load(5'd2, 16'd0, 1, 64'd200, "R10 refreshed kept");
        check_load(5'd2, 16'd64, 1, 64'd208, "R10 new entry");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_store_load();
        t_same_cycle();
        t_fill();
        t_recolor();
        t_wrap();
        t_lru();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule